// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a register-mapped event timer for a host processor. A slow, asynchronous timer clock enters through a synchronizer, and each of its rising edges becomes a one-cycle tick in the bus clock domain. While the timer runs, each tick adds one to a 32-bit event count. When the count reaches a programmed compare value, the block raises an interrupt pulse. In the optional auto-restart mode, the count returns to zero on the tick after a match, so the block produces periodic events. In the other mode the block acts as a one-shot: the interrupt fires once, and software stops the timer.

A count clear is posted. A write to the clear register sets a pending flag in the status register. The clear takes effect only on the next timer-clock edge, and the flag stays up until then. Software polls the flag before it enables the timer again.

The block also holds a free-running counter that never stops. Its tick rate is divided by a ratio of 1 to 4, chosen by a two-bit divider field.

Host access uses a request channel with valid/ready and a registered response channel. The request side never applies back-pressure: `req_ready_o` is high at all times, so a request is taken in every cycle in which `req_valid_i` is high. A read request taken at a clock edge produces `rsp_valid_o` with its data in the following cycle. The response side has no ready input, and the host must accept the response in that cycle.

Top module: `evt_match_timer`

## Requirements
- R1: After reset, every readable register reads zero: compare (0x00), count (0x04), control (0x08), status (0x10), free count (0x14) and divider (0x18). `irq_o` is low.
- R2: While control bit 0 (run) is 1, each rising edge of `tmr_clk_i` increases the count by exactly one. While run is 0, the count holds its value.
- R3: When control bit 1 (auto-restart) is 1 and the count equals the compare value, the next tick loads zero. The count sequence then repeats with a period of compare+1 ticks.
- R4: `irq_o` pulses high for one bus cycle each time a running count advances to the compare value. Loading zero by a clear or by an auto-restart never raises it.
- R5: A write of any data to the clear register (0x0C) sets status bit 10 in the next cycle. On the next timer-clock edge the count becomes zero and bit 10 returns to 0. This happens even while run is 0.
- R6: Until the posted clear has taken effect, the count still reads its old value.
- R7: The free-running counter (0x14) advances once per d+1 timer-clock edges, where d is the divider field (0x18, bits 1:0). It keeps counting whatever the state of run. A write to the divider restarts the division phase.
- R8: `req_ready_o` is always 1. A read returns `rsp_valid_o` high with its data exactly one cycle after the request, and `rsp_valid_o` is low at all other times. An unmapped address reads zero. A write to a read-only or unmapped address changes nothing.
- R9: A new compare value written while the timer runs is used from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk_i | input | 1 | Slow timer clock, asynchronous to `clk` |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
The assertions assume that `tmr_clk_i` stays at each level for at least two bus cycles. This spacing makes consecutive ticks at least two cycles apart, so an interrupt pulse can never run into the next one. The assertions also assume that the host issues at most one request per cycle, with `req_we_i` stable while `req_valid_i` is high. The stimulus drives the timer clock four bus cycles high and four bus cycles low, and it issues bus requests only while the timer clock is at rest. This keeps each tick clear of any register write, so the expected counts follow directly from the number of timer edges applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_CMP   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_FREE  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 6'h18;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int STAT_PEND_BIT = 10;

  typedef struct packed {
    logic auto_rst;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic tick_o
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign tick_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tmr_evt_core.sv
module tmr_evt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_req_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             irq_q;
  logic             at_cmp;
  logic [CNT_W-1:0] cnt_inc;
  logic             restart;
  logic             advance;

  assign at_cmp  = (cnt_q == cmp_i);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign restart = auto_i && at_cmp;
  assign advance = tick_i && !pend_q && run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a new clear request wins over retiring an older one
      if (clr_req_i)   pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;

      if (tick_i && pend_q)  cnt_q <= '0;
      else if (advance)      cnt_q <= restart ? '0 : cnt_inc;

      irq_q <= advance && !restart && (cnt_inc == cmp_i);
    end
  end

  assign count_o = cnt_q;
  assign pend_o  = pend_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_wr_i,
  output logic [CNT_W-1:0] count_o
);
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (div_wr_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      if (pre_q >= div_i) begin
        pre_q <= '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + DIV_W'(1);
      end
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [CNT_W-1:0]  evt_count_i,
  input  logic              pend_i,
  input  logic [CNT_W-1:0]  free_count_i,
  output tmr_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              clr_req_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              div_wr_o
);
  tmr_ctrl_t         ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [DIV_W-1:0]  div_q;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign wr = req_valid_i && req_we_i;
  assign rd = req_valid_i && !req_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      div_q  <= '0;
    end else if (wr) begin
      case (req_addr_i)
        OFF_CMP:  cmp_q <= req_wdata_i[CNT_W-1:0];
        OFF_CTRL: begin
          ctrl_q.run      <= req_wdata_i[CTRL_RUN_BIT];
          ctrl_q.auto_rst <= req_wdata_i[CTRL_AUTO_BIT];
        end
        OFF_DIV:  div_q <= req_wdata_i[DIV_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      OFF_CMP:  rd_mux = DATA_W'(cmp_q);
      OFF_CNT:  rd_mux = DATA_W'(evt_count_i);
      OFF_CTRL: begin
        rd_mux[CTRL_RUN_BIT]  = ctrl_q.run;
        rd_mux[CTRL_AUTO_BIT] = ctrl_q.auto_rst;
      end
      OFF_STAT: rd_mux[STAT_PEND_BIT] = pend_i;
      OFF_FREE: rd_mux = DATA_W'(free_count_i);
      OFF_DIV:  rd_mux = DATA_W'(div_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign cmp_o       = cmp_q;
  assign div_o       = div_q;
  assign clr_req_o   = wr && (req_addr_i == OFF_CLR);
  assign div_wr_o    = wr && (req_addr_i == OFF_DIV);
endmodule

// File: rtl/evt_match_timer.sv
module evt_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clk_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic             tick;
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] cmp;
  logic             clr_req;
  logic [DIV_W-1:0] div;
  logic             div_wr;
  logic [CNT_W-1:0] ev_count;
  logic             pend;
  logic [CNT_W-1:0] free_count;
  logic             run_q;

  assign req_ready_o = 1'b1;
  assign run_q       = ctrl.run;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(tmr_clk_i), .tick_o(tick)
  );

  tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .evt_count_i(ev_count), .pend_i(pend), .free_count_i(free_count),
    .ctrl_o(ctrl), .cmp_o(cmp), .clr_req_o(clr_req),
    .div_o(div), .div_wr_o(div_wr)
  );

  tmr_evt_core #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .run_i(ctrl.run), .auto_i(ctrl.auto_rst), .cmp_i(cmp),
    .clr_req_i(clr_req), .count_o(ev_count), .pend_o(pend), .irq_o(irq_o)
  );

  tmr_free_ctr #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_free (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .div_i(div), .div_wr_i(div_wr), .count_o(free_count)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_we,
  input logic             rsp_valid,
  input logic             irq,
  input logic             ev_run,
  input logic             ev_pend,
  input logic [CNT_W-1:0] ev_count
);
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid); // R8

  AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_we) |=> !rsp_valid); // R8

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_run && !ev_pend) |=> $stable(ev_count)); // R2

  AST_CLEAR_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ev_pend) |-> (ev_count == '0)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ev_count) |-> (ev_count == '0 || ev_count == $past(ev_count) + CNT_W'(1))); // R2
endmodule

bind evt_match_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .req_we(req_we_i),
  .rsp_valid(rsp_valid_o), .irq(irq_o), .ev_run(run_q), .ev_pend(pend),
  .ev_count(ev_count)
);

// File: tb/sim_evt_match_timer.sv
`timescale 1ns/1ps
module sim_evt_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int tests = 0, fails = 0, irq_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tmr_clk_i(tmr_clk),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic tpulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_clk = 1'b1;
      repeat (4) @(negedge clk);
      tmr_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // expected count after n ticks from zero
  function automatic int unsigned model_cnt(int unsigned m, bit au, int n);
    int unsigned c = 0;
    for (int i = 0; i < n; i++) c = (au && c == m) ? 0 : c + 1;
    return c;
  endfunction

  function automatic int model_irq(int unsigned m, bit au, int n);
    int unsigned c = 0;
    int k = 0;
    for (int i = 0; i < n; i++) begin
      if (au && c == m) c = 0;
      else begin c = c + 1; if (c == m) k++; end
    end
    return k;
  endfunction

  task automatic zero_count();
    wr(6'h08, 32'd0);
    wr(6'h0C, 32'd0);
    tpulse(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, f0, f1;
    int i0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check("R1 compare", v, 0);
    rd(6'h04, v); check("R1 count", v, 0);
    rd(6'h08, v); check("R1 control", v, 0);
    rd(6'h10, v); check("R1 status", v, 0);
    rd(6'h14, v); check("R1 free", v, 0);
    rd(6'h18, v); check("R1 divider", v, 0);
    check("R1 irq", irq_cnt, 0);
    check("R8 ready", {31'b0, req_ready}, 1);

    // R2 counting and freezing
    wr(6'h00, 32'd1000);
    wr(6'h08, 32'd1);
    tpulse(5);
    rd(6'h04, v); check("R2 run count", v, 5);
    wr(6'h08, 32'd0);
    tpulse(3);
    rd(6'h04, v); check("R2 frozen count", v, 5);

    // R5 / R6 posted clear while stopped
    wr(6'h0C, 32'hDEADBEEF);
    rd(6'h10, v); check("R5 pending set", v, 32'h400);
    rd(6'h04, v); check("R6 count before edge", v, 5);
    tpulse(1);
    rd(6'h10, v); check("R5 pending released", v, 0);
    rd(6'h04, v); check("R5 count cleared", v, 0);

    // R4 one-shot match
    i0 = irq_cnt;
    wr(6'h00, 32'd3);
    wr(6'h08, 32'd1);
    tpulse(5);
    rd(6'h04, v); check("R4 count past match", v, 5);
    check("R4 irq once", irq_cnt - i0, 1);

    // R3 auto-restart
    zero_count();
    i0 = irq_cnt;
    wr(6'h00, 32'd4);
    wr(6'h08, 32'd3);
    tpulse(10);
    rd(6'h04, v); check("R3 restart count", v, 0);
    check("R3 R4 irq per period", irq_cnt - i0, 2);

    // R9 compare change while running
    zero_count();
    i0 = irq_cnt;
    wr(6'h00, 32'd100);
    wr(6'h08, 32'd1);
    tpulse(2);
    wr(6'h00, 32'd4);
    tpulse(2);
    rd(6'h04, v); check("R9 count", v, 4);
    check("R9 irq on new compare", irq_cnt - i0, 1);

    // R8 read-only and unmapped addresses
    wr(6'h08, 32'd0);
    wr(6'h04, 32'd77);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h04, v); check("R8 count not writable", v, 4);
    rd(6'h3C, v); check("R8 unmapped reads zero", v, 0);
    rd(6'h00, v); check("R8 compare untouched", v, 4);
    @(negedge clk);
    check("R8 no stray rsp_valid", {31'b0, rsp_valid}, 0);

    // R7 free-running divider
    for (int d = 0; d < 4; d++) begin
      wr(6'h18, d);
      rd(6'h14, f0);
      tpulse(13);
      rd(6'h14, f1);
      check("R7 free advance", f1 - f0, 13 / (d + 1));
    end

    // R2 R3 R4 constrained random runs
    for (int k = 0; k < 8; k++) begin
      int unsigned m;
      bit au;
      int n;
      m  = 3 + ($urandom % 10);
      au = 1'($urandom % 2);
      n  = 5 + ($urandom % 26);
      zero_count();
      i0 = irq_cnt;
      wr(6'h00, m);
      wr(6'h08, {30'b0, au, 1'b1});
      tpulse(n);
      wr(6'h08, 32'd0);
      rd(6'h04, v); check("R2 R3 random count", v, model_cnt(m, au, n));
      check("R4 random irq count", irq_cnt - i0, model_irq(m, au, n));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule